// File: doc/BRIEF.md
# Prescaled Programmable Baud Generator

This block derives the timing for one serial channel from a single reference clock. It produces two outputs. The first is a one-cycle enable at sixteen times the baud rate, which the transmitter and the receiver share. The second is a square wave at the same rate, for use off the block.

The reference clock first passes through a prescaler. The prescaler divides by 1 or by 4, and a control input selects which. The prescaled steps then drive a 16-bit down-divider whose value the host writes one byte at a time. The resulting baud rate is f_ref / (prescale × divisor × 16). For example, a 24 MHz reference with a divisor of 1 and no prescale gives 1.5 Mbps.

Any write to a divisor byte restarts the count at once. A divisor of zero parks both outputs.

Top module: `baud_gen`

## Requirements
- R1: A write strobe on `div_lo_we_i` loads `wdata_i` into divisor bits 7:0, and one on `div_hi_we_i` loads bits 15:8. The divisor is visible on `div_o` from the cycle after the write edge.
- R2: With `prescale_sel_i` = 0 and divisor D ≥ 1, `tick_o` rises every D reference cycles.
- R3: With `prescale_sel_i` = 1 and divisor D ≥ 1, `tick_o` rises every 4·D reference cycles.
- R4: When the period is longer than one cycle, `tick_o` is high for exactly one cycle per period.
- R5: `baudout_o` is high for prescale·ceil(D/2) cycles of each prescale·D-cycle period. It is high in every cycle where `tick_o` is high, so D = 1 holds it constantly high.
- R6: With a divisor of 0, `tick_o` never pulses and `baudout_o` stays low.
- R7: A divisor byte write restarts both counters. `tick_o` stays low in the cycle after the write edge. The first tick then comes exactly prescale·D cycles after the last write edge, whatever count was in progress.
- R8: A change of `prescale_sel_i` takes effect only at a prescaler boundary. While the mode changes, each tick-to-tick interval lies between D and 4·D cycles. From the next full period on, the interval equals the new period.
- R9: During and just after reset, `tick_o` and `baudout_o` are low and `div_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_lo_we_i | input | 1 | Write strobe for divisor low byte |
| div_hi_we_i | input | 1 | Write strobe for divisor high byte |
| wdata_i | input | 8 | Divisor byte write data |
| prescale_sel_i | input | 1 | 0: divide by 1, 1: divide by 4 ahead of divisor |
| div_o | output | 16 | Current divisor value |
| tick_o | output | 1 | One-cycle 16x baud enable |
| baudout_o | output | 1 | 16x baud square wave |

## Verification
The bench targets several corner cases:
- **Divisor of 1, unprescaled.** A design that inserted an idle cycle between ticks would halve the rate.
- **Divisor of 1, prescaled.** Here the square wave must stay high; an off-by-one threshold would make it drop.
- **Odd divisors.** These expose a rounding error in the high-time threshold.
- **Divisor of 65535.** This catches a wrapped counter.
- **A divisor of 0.** A design mishandling this would spin through a 65536-count period instead of parking.

Two further scenarios cover restarts and mode changes:
- **Rewrite in the middle of a long count.** This shows whether a design waits out the old period before honouring the new divisor.
- **Prescaler select toggled mid-period.** Every transitional interval is checked, which would catch a stray short tick.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  typedef enum logic {
    PRE_BYPASS  = 1'b0,
    PRE_QUARTER = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DIV_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              restart_o
);
  logic [DIV_W-1:0] div_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           div_q[l*BYTE_W +: BYTE_W] <= '0;
      else if (lane_we_i[l]) div_q[l*BYTE_W +: BYTE_W] <= wdata_i;
    end

    p_lane_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_we_i[l] |=> div_o[l*BYTE_W +: BYTE_W] == $past(wdata_i));
  end

  assign div_o     = div_q;
  assign restart_o = |lane_we_i;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_gen_pkg::*;
#(
  parameter int RATIO = 4,
  localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic restart_i,
  output logic step_o
);
  logic [CW-1:0] cnt_q;
  pre_mode_e     mode_q;

  // bypass steps every cycle; quarter mode steps on last phase
  assign step_o = (mode_q == PRE_BYPASS) || (cnt_q == CW'(RATIO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= PRE_BYPASS;
    end else if (restart_i || step_o) begin
      cnt_q  <= '0;
      mode_q <= pre_mode_e'(sel_i);
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  p_mode_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(step_o || restart_i));

  p_quarter_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PRE_QUARTER && step_o && !$past(restart_i)) |=> !step_o || restart_i || $past(restart_i)
      || mode_q == PRE_BYPASS);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             baud_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, half;
  logic             div_nz, last, tick_q;

  assign div_nz = |div_i;
  assign last   = cnt_q == (div_i - DIV_W'(1));
  // ceil(D/2) without overflow at D = 2^DIV_W-1
  assign half   = (div_i >> 1) + DIV_W'(div_i[0]);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || !div_nz)  cnt_d = '0;
    else if (step_i && last)   cnt_d = '0;
    else if (step_i)           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= div_nz && step_i && last && !restart_i;
    end
  end

  assign tick_o = tick_q;
  assign baud_o = div_nz && (cnt_q < half);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_nz |-> cnt_q < div_i);

  p_single_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > DIV_W'(1)) |=> !tick_o);

  p_tick_in_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> baud_o);

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_nz |-> !tick_o && !baud_o);

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> cnt_q == '0 && !tick_o);
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int PRE_RATIO = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_lo_we_i,
  input  logic              div_hi_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              prescale_sel_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              tick_o,
  output logic              baudout_o
);
  localparam int LANES = DIV_W / BYTE_W;

  logic [LANES-1:0] lane_we;
  logic [DIV_W-1:0] div_val;
  logic             restart, step;

  assign lane_we = {div_hi_we_i, div_lo_we_i};

  baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_we_i (lane_we),
    .wdata_i   (wdata_i),
    .div_o     (div_val),
    .restart_o (restart)
  );

  baud_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (prescale_sel_i),
    .restart_i (restart),
    .step_o    (step)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .restart_i (restart),
    .div_i     (div_val),
    .tick_o    (tick_o),
    .baud_o    (baudout_o)
  );

  assign div_o = div_val;
endmodule

// File: tb/baud_gen_test.sv
module baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lo_we = 1'b0, hi_we = 1'b0, sel = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] div;
  logic        tick, bo;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  baud_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .div_lo_we_i(lo_we), .div_hi_we_i(hi_we),
    .wdata_i(wdata), .prescale_sel_i(sel), .div_o(div), .tick_o(tick), .baudout_o(bo)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(bit s, int d);
    return (s ? 4 : 1) * d;
  endfunction

  function automatic int exp_high(bit s, int d);
    return (s ? 4 : 1) * ((d + 1) / 2);
  endfunction

  // leaves caller at the negedge right after the high-byte write edge
  task automatic set_div(int d, bit s);
    @(negedge clk); sel = s; lo_we = 1'b1; wdata = d[7:0];
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b1; wdata = d[15:8];
    @(negedge clk); hi_we = 1'b0;
    chk(div == 16'(d), "R1 divisor bytes", int'(div), d);
  endtask

  task automatic run_check(int d, bit s, int nper);
    int p, h, last, hi_cnt, ticks;
    bit prev;
    p = exp_period(s, d);
    h = exp_high(s, d);
    set_div(d, s);
    chk(tick == 1'b0, "R7 no tick after write", int'(tick), 0);
    last = 0; hi_cnt = int'(bo); ticks = 0; prev = 1'b0;
    for (int j = 1; j <= p * nper; j++) begin
      @(negedge clk);
      if (tick) begin
        ticks++;
        if (ticks == 1) chk(j == p, "R7 first tick", j, p);
        else chk(j - last == p, s ? "R3 period" : "R2 period", j - last, p);
        chk(hi_cnt == h, "R5 high time", hi_cnt, h);
        chk(bo == 1'b1, "R5 high at tick", int'(bo), 1);
        chk(!prev || p == 1, "R4 one-cycle tick", int'(prev), 0);
        last = j; hi_cnt = 0;
      end
      if (bo) hi_cnt++;
      prev = tick;
    end
    chk(ticks == nper, s ? "R3 tick count" : "R2 tick count", ticks, nper);
  endtask

  task automatic run_zero(bit s);
    int ticks, highs;
    set_div(0, s);
    ticks = 0; highs = 0;
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      if (tick) ticks++;
      if (bo) highs++;
    end
    chk(ticks == 0, "R6 no tick at zero", ticks, 0);
    chk(highs == 0, "R6 baudout low at zero", highs, 0);
  endtask

  // observe tick intervals for n cycles; returns last interval
  task automatic watch(int n, int lo, int hi, output int last_iv);
    int last;
    last = -1; last_iv = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (tick) begin
        if (last >= 0) begin
          last_iv = j - last;
          chk(last_iv >= lo && last_iv <= hi, "R8 transitional interval", last_iv, lo);
        end
        last = j;
      end
    end
  endtask

  initial begin
    int iv;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R9 tick in reset", int'(tick), 0);
    chk(bo == 1'b0, "R9 baudout in reset", int'(bo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div == 16'd0, "R9 divisor reset", int'(div), 0);
    chk(tick == 1'b0 && bo == 1'b0, "R9 idle after reset", int'({tick, bo}), 0);

    run_check(1, 1'b0, 8);
    run_check(1, 1'b1, 4);
    run_check(2, 1'b0, 4);
    run_check(3, 1'b1, 3);
    run_check(7, 1'b0, 3);
    run_check(256, 1'b0, 2);
    run_zero(1'b0);
    run_zero(1'b1);

    // R7: rewrite in the middle of a long count
    set_div(1000, 1'b0);
    repeat (50) @(negedge clk);
    run_check(9, 1'b1, 3);

    // R8: prescale select change mid-period
    run_check(5, 1'b1, 1);
    repeat (3) @(negedge clk);
    sel = 1'b0;
    watch(80, 5, 20, iv);
    chk(iv == 5, "R8 settled to divide-by-1", iv, 5);
    sel = 1'b1;
    watch(120, 5, 20, iv);
    chk(iv == 20, "R8 settled to divide-by-4", iv, 20);

    for (int k = 0; k < 14; k++) begin
      int d;
      bit s;
      d = 1 + int'($urandom % 60);
      s = 1'($urandom % 2);
      run_check(d, s, 3);
    end

    run_check(65535, 1'b0, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule